// File: doc/BRIEF.md
# Protected-Region-Aware Mass Erase Sequencer

This block runs the wipe that follows a drop in the readout protection level. When it sees a start pulse, it captures its configuration: the full-wipe flag, the secure-enable state, the proprietary-code page window, the secure-area start page and the number of main-flash pages. It then asks the backup registers and three SRAM regions to clear themselves. Next it erases main flash in one of two ways. The first is a single mass-erase command. The second is a walk through the pages in ascending order that issues a page-erase command for every page that is not protected. Once the flash work is complete, it strobes a restore of the saved option values, with proprietary-code protection switched off and the window bounds kept.

The array is reached only through two request/done command channels, one for pages and one for mass erase. Page numbers always stay below the captured page count, so the one-time-programmable area, which lies outside that range, is never addressed. The controller is one state machine: `ST_IDLE` goes to `ST_WIPE` on start. `ST_WIPE` goes to `ST_MASS` in full mode and to `ST_SCAN` otherwise. `ST_MASS` goes to `ST_RESTORE` on mass-erase done. `ST_SCAN` goes to `ST_PAGE` for an unprotected page, stays in `ST_SCAN` and steps past a skipped page, and goes to `ST_RESTORE` when the cursor reaches the count. `ST_PAGE` returns to `ST_SCAN` on page-erase done. `ST_RESTORE` goes to `ST_FINISH`, and `ST_FINISH` goes back to `ST_IDLE`.

Top module: `prot_erase_seq`

## Requirements
- R1: With the full-wipe flag set and secure-enable low, exactly one mass-erase request is made, and no page-erase request is made.
- R2: With the full-wipe flag clear, every page p below the count gets exactly one page erase unless lo <= p <= hi (inclusive window). A window with lo > hi protects nothing.
- R3: With secure-enable high, every page at or above the secure-area start page is skipped. All other pages below the count are erased unless another rule skips them.
- R4: With the full-wipe flag clear and secure-enable high, a page is skipped when it matches either rule.
- R5: Page erases are issued in strictly ascending page order. A request stays high with a stable page number until its done input is seen, and the next request is raised only after that.
- R6: In the first cycle after an accepted start, clear_req_o pulses 4'b1111 for exactly one cycle, before any erase request. Bit 0 is the backup registers, bit 1 general SRAM 1, bit 2 general SRAM 2 and bit 3 the crypto SRAM.
- R7: After the last erase handshake, opt_restore_o pulses for one cycle. During that pulse opt_pcode_en_o is 0, and opt_pcode_lo_o, opt_pcode_hi_o and opt_full_wipe_o equal the values captured at start. No erase request follows the restore.
- R8: No page-erase request carries a page number at or above the captured count. A count of 0 produces no erase command at all.
- R9: busy_o is high from the cycle after start until the restore cycle inclusive. done_o then pulses for one cycle with busy_o low.
- R10: A start pulse while busy is ignored, and input changes after start have no effect on the run in progress.
- R11: During and after reset, every request, strobe, busy_o and done_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only in ST_IDLE |
| full_wipe_i | input | 1 | Full mass erase requested on regression |
| secure_en_i | input | 1 | Secure-area enable |
| pcode_lo_i | input | PAGE_W | First page of the proprietary-code window |
| pcode_hi_i | input | PAGE_W | Last page of the proprietary-code window |
| sec_start_i | input | PAGE_W | First page of the secure area |
| page_count_i | input | PAGE_W+1 | Number of main-flash pages |
| pg_erase_req_o | output | 1 | Page-erase request |
| pg_erase_page_o | output | PAGE_W | Page to erase |
| pg_erase_done_i | input | 1 | Page-erase completion |
| mass_erase_req_o | output | 1 | Mass-erase request |
| mass_erase_done_i | input | 1 | Mass-erase completion |
| clear_req_o | output | 4 | Clear pulses: backup, SRAM 1, SRAM 2, crypto SRAM |
| opt_restore_o | output | 1 | Option restore strobe |
| opt_full_wipe_o | output | 1 | Restored full-wipe flag |
| opt_pcode_en_o | output | 1 | Restored proprietary-code protection enable (always off) |
| opt_pcode_lo_o | output | PAGE_W | Restored window start |
| opt_pcode_hi_o | output | PAGE_W | Restored window end |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that the done inputs rise only while the matching request is high and drop before another request can be raised. The bench stub answers each request after a fixed wait and clears done at the next falling edge, so this holds. The assertions also assume the count fits PAGE_W+1 bits and the window bounds are page numbers. The stimulus table uses only legal page numbers, and it deliberately includes an inverted window, a zero count and the full 64-page count.

// File: rtl/mers_pkg.sv
package mers_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WIPE,
        ST_MASS,
        ST_SCAN,
        ST_PAGE,
        ST_RESTORE,
        ST_FINISH
    } seq_state_e;

    // Clear-request bit positions
    localparam int CLR_BACKUP = 0;
    localparam int CLR_SRAM1  = 1;
    localparam int CLR_SRAM2  = 2;
    localparam int CLR_CRYPTO = 3;
    localparam int CLR_N      = 4;

endpackage

// File: rtl/mers_opt_hold.sv
// Captures the run configuration at start so later input changes are ignored.
module mers_opt_hold #(
    parameter int PAGE_W = 6,
    parameter int CNT_W  = PAGE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_i,
    input  logic              full_i,
    input  logic              sec_i,
    input  logic [PAGE_W-1:0] lo_i,
    input  logic [PAGE_W-1:0] hi_i,
    input  logic [PAGE_W-1:0] ss_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic              full_q,
    output logic              sec_q,
    output logic [PAGE_W-1:0] lo_q,
    output logic [PAGE_W-1:0] hi_q,
    output logic [PAGE_W-1:0] ss_q,
    output logic [CNT_W-1:0]  cnt_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            sec_q  <= 1'b0;
            lo_q   <= '0;
            hi_q   <= '0;
            ss_q   <= '0;
            cnt_q  <= '0;
        end else if (capture_i) begin
            full_q <= full_i;
            sec_q  <= sec_i;
            lo_q   <= lo_i;
            hi_q   <= hi_i;
            ss_q   <= ss_i;
            cnt_q  <= cnt_i;
        end
    end

    // Captured values hold while no capture is requested
    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !capture_i |=> $stable(cnt_q) && $stable(lo_q) && $stable(hi_q)); // R10

endmodule

// File: rtl/mers_page_filter.sv
// Decides the erase mode and whether the current page is protected.
module mers_page_filter #(
    parameter int PAGE_W = 6
) (
    input  logic [PAGE_W-1:0] page_i,
    input  logic              full_i,
    input  logic              sec_i,
    input  logic [PAGE_W-1:0] lo_i,
    input  logic [PAGE_W-1:0] hi_i,
    input  logic [PAGE_W-1:0] ss_i,
    output logic              use_mass_o,
    output logic              skip_o
);

    logic in_pcode;
    logic in_secure;

    always_comb begin
        in_pcode   = (page_i >= lo_i) && (page_i <= hi_i);
        in_secure  = (page_i >= ss_i);
        // Whole-array erase is allowed only when no secure area must survive
        use_mass_o = full_i && !sec_i;
        // Either protection rule is enough to keep the page
        skip_o     = (!full_i && in_pcode) || (sec_i && in_secure);
    end

endmodule

// File: rtl/mers_page_cursor.sv
// Ascending page index with an end-of-range flag.
module mers_page_cursor #(
    parameter int PAGE_W = 6,
    parameter int CNT_W  = PAGE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              step_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic [PAGE_W-1:0] page_o,
    output logic              at_end_o
);

    logic [CNT_W-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (clear_i) begin
            idx_q <= '0;
        end else if (step_i && (idx_q < count_i)) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    assign page_o   = idx_q[PAGE_W-1:0];
    assign at_end_o = (idx_q >= count_i);

    AST_IDX_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> idx_q >= $past(idx_q)); // R5

endmodule

// File: rtl/prot_erase_seq.sv
module prot_erase_seq
    import mers_pkg::*;
#(
    parameter  int PAGE_W = 6,
    localparam int CNT_W  = PAGE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              full_wipe_i,
    input  logic              secure_en_i,
    input  logic [PAGE_W-1:0] pcode_lo_i,
    input  logic [PAGE_W-1:0] pcode_hi_i,
    input  logic [PAGE_W-1:0] sec_start_i,
    input  logic [CNT_W-1:0]  page_count_i,
    output logic              pg_erase_req_o,
    output logic [PAGE_W-1:0] pg_erase_page_o,
    input  logic              pg_erase_done_i,
    output logic              mass_erase_req_o,
    input  logic              mass_erase_done_i,
    output logic [3:0]        clear_req_o,
    output logic              opt_restore_o,
    output logic              opt_full_wipe_o,
    output logic              opt_pcode_en_o,
    output logic [PAGE_W-1:0] opt_pcode_lo_o,
    output logic [PAGE_W-1:0] opt_pcode_hi_o,
    output logic              busy_o,
    output logic              done_o
);

    seq_state_e state_q, state_d;

    logic              capture;
    logic              full_q, sec_q;
    logic [PAGE_W-1:0] lo_q, hi_q, ss_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [PAGE_W-1:0] cur_page;
    logic              at_end;
    logic              use_mass;
    logic              page_skip;
    logic              step;
    logic              wipe_now;

    assign capture = (state_q == ST_IDLE) && start_i;

    mers_opt_hold #(.PAGE_W(PAGE_W), .CNT_W(CNT_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (capture),
        .full_i    (full_wipe_i),
        .sec_i     (secure_en_i),
        .lo_i      (pcode_lo_i),
        .hi_i      (pcode_hi_i),
        .ss_i      (sec_start_i),
        .cnt_i     (page_count_i),
        .full_q    (full_q),
        .sec_q     (sec_q),
        .lo_q      (lo_q),
        .hi_q      (hi_q),
        .ss_q      (ss_q),
        .cnt_q     (cnt_q)
    );

    mers_page_cursor #(.PAGE_W(PAGE_W), .CNT_W(CNT_W)) u_cursor (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (capture),
        .step_i   (step),
        .count_i  (cnt_q),
        .page_o   (cur_page),
        .at_end_o (at_end)
    );

    mers_page_filter #(.PAGE_W(PAGE_W)) u_filter (
        .page_i     (cur_page),
        .full_i     (full_q),
        .sec_i      (sec_q),
        .lo_i       (lo_q),
        .hi_i       (hi_q),
        .ss_i       (ss_q),
        .use_mass_o (use_mass),
        .skip_o     (page_skip)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and cursor step
    always_comb begin
        state_d = state_q;
        step    = 1'b0;
        unique case (state_q)
            ST_IDLE:    if (start_i) state_d = ST_WIPE;
            ST_WIPE:    state_d = use_mass ? ST_MASS : ST_SCAN;
            ST_MASS:    if (mass_erase_done_i) state_d = ST_RESTORE;
            ST_SCAN: begin
                if (at_end) begin
                    state_d = ST_RESTORE;
                end else if (page_skip) begin
                    step    = 1'b1;
                end else begin
                    state_d = ST_PAGE;
                end
            end
            ST_PAGE: begin
                if (pg_erase_done_i) begin
                    step    = 1'b1;
                    state_d = ST_SCAN;
                end
            end
            ST_RESTORE: state_d = ST_FINISH;
            ST_FINISH:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    assign wipe_now = (state_q == ST_WIPE);

    // One clear line per retained-memory region
    for (genvar g = 0; g < CLR_N; g++) begin : g_clr
        assign clear_req_o[g] = wipe_now;
    end

    // Outputs decoded from state
    always_comb begin
        pg_erase_req_o   = 1'b0;
        mass_erase_req_o = 1'b0;
        opt_restore_o    = 1'b0;
        busy_o           = 1'b0;
        done_o           = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_WIPE:    busy_o = 1'b1;
            ST_MASS:    begin busy_o = 1'b1; mass_erase_req_o = 1'b1; end
            ST_SCAN:    busy_o = 1'b1;
            ST_PAGE:    begin busy_o = 1'b1; pg_erase_req_o = 1'b1; end
            ST_RESTORE: begin busy_o = 1'b1; opt_restore_o = 1'b1; end
            ST_FINISH:  done_o = 1'b1;
            default:    ;
        endcase
    end

    assign pg_erase_page_o = cur_page;
    // Restored options: protection enable forced off, bounds and flag kept
    assign opt_pcode_en_o  = 1'b0;
    assign opt_pcode_lo_o  = opt_restore_o ? lo_q : '0;
    assign opt_pcode_hi_o  = opt_restore_o ? hi_q : '0;
    assign opt_full_wipe_o = opt_restore_o ? full_q : 1'b0;

    AST_CMD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(pg_erase_req_o && mass_erase_req_o)); // R1
    AST_MASS_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        mass_erase_req_o |-> full_q && !sec_q); // R1
    AST_PAGE_NOT_SKIPPED: assert property (@(posedge clk) disable iff (!rst_n)
        pg_erase_req_o |-> !page_skip); // R2
    AST_PAGE_BELOW_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        pg_erase_req_o |-> ({1'b0, pg_erase_page_o} < cnt_q)); // R8
    AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        pg_erase_req_o && !pg_erase_done_i |=> pg_erase_req_o && $stable(pg_erase_page_o)); // R5
    AST_CLEAR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (|clear_req_o) |=> clear_req_o == 4'b0000); // R6
    AST_BUSY_END_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o); // R9
    AST_NO_ERASE_AT_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        opt_restore_o |-> !pg_erase_req_o && !mass_erase_req_o); // R7

endmodule

// File: tb/prot_erase_seq_bench.sv
`timescale 1ns/1ps
module prot_erase_seq_bench;

    localparam int PAGE_W = 6;
    localparam int CNT_W  = PAGE_W + 1;
    localparam int NVEC   = 9;

    // {full, secure, lo, hi, sec_start, count}
    localparam logic [26:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 6'd0,  6'd0,  6'd0,  7'd16},
        {1'b0, 1'b0, 6'd4,  6'd9,  6'd0,  7'd16},
        {1'b1, 1'b1, 6'd0,  6'd0,  6'd10, 7'd16},
        {1'b0, 1'b1, 6'd2,  6'd3,  6'd12, 7'd16},
        {1'b0, 1'b0, 6'd0,  6'd0,  6'd0,  7'd8},
        {1'b0, 1'b0, 6'd60, 6'd63, 6'd0,  7'd64},
        {1'b1, 1'b1, 6'd0,  6'd0,  6'd0,  7'd8},
        {1'b0, 1'b0, 6'd5,  6'd2,  6'd0,  7'd10},
        {1'b0, 1'b0, 6'd1,  6'd2,  6'd0,  7'd0}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic              full_wipe_i = 1'b0;
    logic              secure_en_i = 1'b0;
    logic [PAGE_W-1:0] pcode_lo_i = '0;
    logic [PAGE_W-1:0] pcode_hi_i = '0;
    logic [PAGE_W-1:0] sec_start_i = '0;
    logic [CNT_W-1:0]  page_count_i = '0;
    logic              pg_erase_req_o;
    logic [PAGE_W-1:0] pg_erase_page_o;
    logic              pg_erase_done_i = 1'b0;
    logic              mass_erase_req_o;
    logic              mass_erase_done_i = 1'b0;
    logic [3:0]        clear_req_o;
    logic              opt_restore_o;
    logic              opt_full_wipe_o;
    logic              opt_pcode_en_o;
    logic [PAGE_W-1:0] opt_pcode_lo_o;
    logic [PAGE_W-1:0] opt_pcode_hi_o;
    logic              busy_o;
    logic              done_o;

    always #2 clk = ~clk;

    prot_erase_seq #(.PAGE_W(PAGE_W)) u_prot_erase_seq (.*);

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // Monitor state
    bit          mon_on = 0;
    bit          running = 0;
    logic [63:0] pg_map;
    int          mass_cnt, clr_cnt, clr_bad, dup_cnt, order_bad, late_cnt;
    int          restore_cnt, done_cnt, busy_bad, pg_wait, ms_wait, last_pg;
    bit          any_pg, pg_prev, mass_prev;
    logic [PAGE_W-1:0] r_lo, r_hi;
    logic        r_en, r_full;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic clear_log();
        pg_map = '0; mass_cnt = 0; clr_cnt = 0; clr_bad = 0; dup_cnt = 0;
        order_bad = 0; late_cnt = 0; restore_cnt = 0; done_cnt = 0;
        busy_bad = 0; any_pg = 0; last_pg = -1;
        r_lo = '0; r_hi = '0; r_en = 1'b1; r_full = 1'b0;
    endtask

    // Monitor and array stub, both at the falling edge
    always @(negedge clk) begin
        if (mon_on) begin
            if (|clear_req_o) begin
                if (clear_req_o == 4'b1111) clr_cnt++; else clr_bad++;
                if (any_pg || mass_cnt > 0) clr_bad++;
            end
            if (mass_erase_req_o && !mass_prev) mass_cnt++;
            if (pg_erase_req_o && !pg_prev) begin
                if (pg_map[pg_erase_page_o]) dup_cnt++;
                if (any_pg && int'(pg_erase_page_o) <= last_pg) order_bad++;
                if (clr_cnt == 0) clr_bad++;
                pg_map[pg_erase_page_o] = 1'b1;
                last_pg = int'(pg_erase_page_o);
                any_pg = 1;
                if (restore_cnt > 0) late_cnt++;
            end
            if (opt_restore_o) begin
                restore_cnt++;
                r_lo = opt_pcode_lo_o; r_hi = opt_pcode_hi_o;
                r_en = opt_pcode_en_o; r_full = opt_full_wipe_o;
                if (pg_erase_req_o || mass_erase_req_o) late_cnt++;
            end
            if (done_o) begin
                done_cnt++;
                if (busy_o) busy_bad++;
            end
            if (running && !busy_o && restore_cnt == 0) busy_bad++;
        end
        pg_prev   = pg_erase_req_o;
        mass_prev = mass_erase_req_o;
        // Stub: answer each request after a fixed wait
        pg_erase_done_i   = 1'b0;
        mass_erase_done_i = 1'b0;
        if (pg_erase_req_o) begin
            if (pg_wait == 2) begin pg_erase_done_i = 1'b1; pg_wait = 0; end
            else pg_wait++;
        end else pg_wait = 0;
        if (mass_erase_req_o) begin
            if (ms_wait == 3) begin mass_erase_done_i = 1'b1; ms_wait = 0; end
            else ms_wait++;
        end else ms_wait = 0;
    end

    function automatic logic [63:0] exp_map(input bit f, input bit s, input int lo,
                                            input int hi, input int ss, input int cnt);
        logic [63:0] m = '0;
        if (f && !s) return m;
        for (int p = 0; p < cnt; p++) begin
            bit skip = (!f && p >= lo && p <= hi) || (s && p >= ss);
            if (!skip) m[p] = 1'b1;
        end
        return m;
    endfunction

    task automatic run(input logic [26:0] v, input bit poke, input string tag);
        bit f = v[26];
        bit s = v[25];
        int lo = int'(v[24:19]);
        int hi = int'(v[18:13]);
        int ss = int'(v[12:7]);
        int cnt = int'(v[6:0]);
        int wait_cyc = 0;
        clear_log();
        mon_on = 1;
        @(posedge clk); #1;
        full_wipe_i = f; secure_en_i = s;
        pcode_lo_i = v[24:19]; pcode_hi_i = v[18:13];
        sec_start_i = v[12:7]; page_count_i = v[6:0];
        start_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0;
        running = 1;
        if (poke) begin
            repeat (5) @(posedge clk);
            #1;
            // R10: new config and a second start while busy
            full_wipe_i = 1'b1; secure_en_i = 1'b0; page_count_i = 7'd4;
            pcode_lo_i = 6'd0; pcode_hi_i = 6'd1;
            start_i = 1'b1;
            @(posedge clk); #1;
            start_i = 1'b0;
        end
        while (done_cnt == 0 && wait_cyc < 3000) begin
            @(posedge clk); #1;
            wait_cyc++;
        end
        running = 0;
        repeat (6) @(posedge clk);
        #1;
        mon_on = 0;
        chk(wait_cyc < 3000, tag, "run completes", 64'(wait_cyc), 64'd3000);
        chk(pg_map == exp_map(f, s, lo, hi, ss, cnt), (f && !s) ? "R1" : (s ? (f ? "R3" : "R4") : "R2"),
            {tag, " erased page map"}, pg_map, exp_map(f, s, lo, hi, ss, cnt));
        chk(mass_cnt == ((f && !s) ? 1 : 0), "R1", {tag, " mass erase count"},
            64'(mass_cnt), (f && !s) ? 64'd1 : 64'd0);
        chk(dup_cnt == 0 && order_bad == 0, "R5", {tag, " ascending single erase"},
            64'(dup_cnt + order_bad), 64'd0);
        chk(clr_cnt == 1 && clr_bad == 0, "R6", {tag, " clear pulse"},
            64'(clr_cnt), 64'd1);
        chk(restore_cnt == 1 && late_cnt == 0 && r_en == 1'b0 && r_lo == v[24:19]
            && r_hi == v[18:13] && r_full == f, "R7", {tag, " option restore"},
            {r_full, r_en, r_lo, r_hi}, {f, 1'b0, v[24:19], v[18:13]});
        chk(done_cnt == 1 && busy_bad == 0, "R9", {tag, " busy and done"},
            64'(done_cnt + busy_bad * 16), 64'd1);
        if (cnt == 0)
            chk(pg_map == '0 && mass_cnt == 0, "R8", {tag, " zero count"}, pg_map, 64'd0);
    endtask

    task automatic chk_idle(input string what);
        chk(!pg_erase_req_o && !mass_erase_req_o && clear_req_o == 4'b0 && !opt_restore_o
            && !busy_o && !done_o, "R11", what,
            {pg_erase_req_o, mass_erase_req_o, clear_req_o, opt_restore_o, busy_o, done_o},
            64'd0);
    endtask

    initial begin
        clear_log();
        repeat (3) @(posedge clk);
        #1;
        chk_idle("outputs in reset");
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        chk_idle("outputs after reset");

        for (int i = 0; i < NVEC; i++) begin
            run(VEC[i], 1'b0, $sformatf("vec%0d", i));
        end

        // R10: restart and config change while busy are ignored
        run(VEC[1], 1'b1, "R10 poke");

        // R11: reset in the middle of a page walk
        @(posedge clk); #1;
        full_wipe_i = 1'b0; secure_en_i = 1'b0; page_count_i = 7'd20;
        pcode_lo_i = 6'd40; pcode_hi_i = 6'd41;
        start_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0;
        repeat (9) @(posedge clk);
        #1;
        chk(busy_o, "R9", "busy mid run", 64'(busy_o), 64'd1);
        rst_n = 1'b0;
        #1;
        chk_idle("outputs on mid-run reset");
        @(posedge clk); #1;
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk_idle("idle after mid-run reset");

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        end
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog run did not finish actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        end
        $finish;
    end

endmodule